// File: doc/BRIEF.md
# Touch ADC Conversion and Power Sequencer

This block is the control logic of a resistive-touch converter front end. A decoded command carries a resolution select and a two-bit power-down code. While idle, the block accepts such a command. It then derives a converter clock enable from the master clock. The divide ratio depends on the resolution, so 8-bit work runs at twice the converter rate of 12-bit work. The block steps through an acquisition phase and one converter clock per result bit, and ends with a single-cycle done strobe.

The comparator decision arrives on a one-bit stub input. The block shifts it into a result register, most significant bit first. The power code is held from the accepted command and decides the state of the front end once the conversion ends: whether the converter stays powered, whether the touch drivers stay on for the next measurement, whether the pen interrupt is armed, and whether the Y-minus switch is closed. While a conversion runs, the front end is always fully on.

Top module: `touch_adc_seq`

## Requirements
- R1: After reset, busy and done are 0, the converter is unpowered, the drivers are off, the pen interrupt is enabled and the Y-minus switch is closed.
- R2: With the resolution input at 1 (12-bit), the converter clock enable fires every 8 master cycles. Done rises exactly 128 master clock edges after the accepting edge, which is 16 converter clocks.
- R3: With the resolution input at 0 (8-bit), the converter clock enable fires every 4 master cycles. Done rises exactly 48 master clock edges after the accepting edge, which is 12 converter clocks and so four fewer than 12-bit.
- R4: The first 4 converter clocks are acquisition. On each later converter clock the stub bit is shifted in at the LSB, so the first bit taken ends as the MSB. The result is right-justified, and bits above the resolution read 0.
- R5: Busy is 1 from the accepting edge until the edge that raises done. Done lasts one master cycle, and busy is 0 while done is 1.
- R6: While busy, the converter is powered and the drivers are on, the pen interrupt is disabled and the Y-minus switch is open.
- R7: Power code 00 (bit 1, bit 0): once the conversion ends, the converter is unpowered, the drivers are off, the pen interrupt is enabled and Y-minus is closed.
- R8: Power code 01: once the conversion ends, the converter stays powered, the drivers stay on, the pen interrupt is disabled and Y-minus is open.
- R9: Power code 10: once the conversion ends, the converter is off, the drivers are off, the pen interrupt is enabled and Y-minus is closed.
- R10: Power code 11: once the conversion ends, the converter stays powered, the drivers stay on and the pen interrupt is disabled.
- R11: A command presented while busy is ignored. The conversion length, the result and the power state after done are those of the command that was accepted.
- R12: A command accepted from a powered-down idle state needs no extra wake-up cycles. Its conversion length equals the nominal length for its resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (16 MHz nominal) |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken only while idle |
| cmdHiRes | input | 1 | 1 selects 12-bit, 0 selects 8-bit |
| cmdPd | input | 2 | Power-down code applied after the conversion |
| cmpBit | input | 1 | Comparator decision stub |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion strobe |
| result | output | 12 | Right-justified conversion result |
| adcPowered | output | 1 | Converter power enable |
| drvOn | output | 1 | Touch-screen driver enable |
| penIrqEn | output | 1 | Pen interrupt armed |
| yMinusOn | output | 1 | Y-minus switch closed |

## Verification
The bench counts master edges from the accepting edge to done for both resolutions. A divider that picked the wrong ratio, or a counter that took one clock too many or too few, shows up as a miscount. The comparator stub is driven with an asymmetric bit pattern, one bit per converter clock. Bit-order reversal, capture during acquisition or stale upper bits then give the wrong result. A second command injected mid-conversion, with the opposite resolution and power code, catches a design that restarts, relatches the code or changes its divider. Each power code is checked after done and compared with the state during the conversion.

// File: rtl/touch_adc_pkg.sv
package touch_adc_pkg;
  typedef struct packed {
    logic clear;
    logic shiftEn;
    logic latchPd;
  } ctrlStrobes_t;
endpackage

// File: rtl/touch_adc_ctrl.sv
module touch_adc_ctrl
  import touch_adc_pkg::*;
#(
  parameter int DIV_HI   = 8,
  parameter int DIV_LO   = 4,
  parameter int ACQ_CLKS = 4,
  parameter int RES_HI   = 12,
  parameter int RES_LO   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         cmdHiRes,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);
  localparam int PRESC_W  = $clog2(DIV_HI);
  localparam int DIV_W    = PRESC_W + 1;
  localparam int CONV_MAX = ACQ_CLKS + RES_HI;
  localparam int CNT_W    = $clog2(CONV_MAX + 1);

  logic               busyQ, hiResQ, doneQ;
  logic [PRESC_W-1:0] prescQ;
  logic [CNT_W-1:0]   clkCntQ;
  logic [DIV_W-1:0]   divisor;
  logic [CNT_W-1:0]   total;
  logic               accept, tick, lastTick, bitTick;

  assign accept   = cmdValid && !busyQ;
  assign divisor  = hiResQ ? DIV_W'(DIV_HI) : DIV_W'(DIV_LO);
  assign total    = hiResQ ? CNT_W'(CONV_MAX) : CNT_W'(ACQ_CLKS + RES_LO);
  assign tick     = busyQ && ({1'b0, prescQ} == divisor - 1'b1);
  assign lastTick = tick && (clkCntQ == total - 1'b1);
  assign bitTick  = tick && (clkCntQ >= CNT_W'(ACQ_CLKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      hiResQ  <= 1'b0;
      doneQ   <= 1'b0;
      prescQ  <= '0;
      clkCntQ <= '0;
    end else begin
      doneQ <= lastTick;
      if (accept) begin
        busyQ   <= 1'b1;
        hiResQ  <= cmdHiRes;
        prescQ  <= '0;
        clkCntQ <= '0;
      end else if (busyQ) begin
        if (tick) begin
          prescQ  <= '0;
          clkCntQ <= clkCntQ + 1'b1;
        end else begin
          prescQ <= prescQ + 1'b1;
        end
        if (lastTick) busyQ <= 1'b0;
      end
    end
  end

  assign busy            = busyQ;
  assign done            = doneQ;
  assign strobes.clear   = accept;
  assign strobes.latchPd = accept;
  assign strobes.shiftEn = bitTick;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R5
  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> ({1'b0, prescQ} < divisor)); // R2
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> $stable(hiResQ)); // R11
endmodule

// File: rtl/touch_adc_path.sv
module touch_adc_path
  import touch_adc_pkg::*;
#(
  parameter int RES_HI = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [1:0]        cmdPd,
  input  logic              cmpBit,
  input  logic              busy,
  output logic [RES_HI-1:0] result,
  output logic              adcPowered,
  output logic              drvOn,
  output logic              penIrqEn,
  output logic              yMinusOn
);
  logic [1:0]        pdQ;
  logic [RES_HI-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdQ    <= 2'b00;
      shiftQ <= '0;
    end else begin
      if (strobes.latchPd) pdQ <= cmdPd;
      if (strobes.clear) shiftQ <= '0;
      else if (strobes.shiftEn) shiftQ <= {shiftQ[RES_HI-2:0], cmpBit};
    end
  end

  always_comb begin
    if (busy) begin
      adcPowered = 1'b1;
      drvOn      = 1'b1;
      penIrqEn   = 1'b0;
      yMinusOn   = 1'b0;
    end else begin
      adcPowered = pdQ[0];
      drvOn      = pdQ[0];
      penIrqEn   = !pdQ[0];
      yMinusOn   = !pdQ[0];
    end
  end

  assign result = shiftQ;

  AST_FULL_POWER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (adcPowered && drvOn && !penIrqEn && !yMinusOn)); // R6
  AST_PEN_VS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (penIrqEn != adcPowered)); // R7
  AST_PD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(pdQ)); // R11
endmodule

// File: rtl/touch_adc_seq.sv
module touch_adc_seq
  import touch_adc_pkg::*;
#(
  parameter int DIV_HI   = 8,
  parameter int DIV_LO   = 4,
  parameter int ACQ_CLKS = 4,
  parameter int RES_HI   = 12,
  parameter int RES_LO   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdHiRes,
  input  logic [1:0]        cmdPd,
  input  logic              cmpBit,
  output logic              busy,
  output logic              done,
  output logic [RES_HI-1:0] result,
  output logic              adcPowered,
  output logic              drvOn,
  output logic              penIrqEn,
  output logic              yMinusOn
);
  ctrlStrobes_t strobes;

  touch_adc_ctrl #(
    .DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .ACQ_CLKS(ACQ_CLKS),
    .RES_HI(RES_HI), .RES_LO(RES_LO)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdHiRes(cmdHiRes),
    .busy(busy), .done(done), .strobes(strobes)
  );

  touch_adc_path #(.RES_HI(RES_HI)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdPd(cmdPd),
    .cmpBit(cmpBit), .busy(busy), .result(result),
    .adcPowered(adcPowered), .drvOn(drvOn), .penIrqEn(penIrqEn),
    .yMinusOn(yMinusOn)
  );
endmodule

// File: tb/touch_adc_seq_tb.sv
module touch_adc_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdHiRes = 1'b0;
  logic [1:0] cmdPd = 2'b00;
  logic cmpBit = 1'b0;
  logic busy, done, adcPowered, drvOn, penIrqEn, yMinusOn;
  logic [11:0] result;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  touch_adc_seq dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdHiRes(cmdHiRes),
    .cmdPd(cmdPd), .cmpBit(cmpBit), .busy(busy), .done(done),
    .result(result), .adcPowered(adcPowered), .drvOn(drvOn),
    .penIrqEn(penIrqEn), .yMinusOn(yMinusOn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pwrVec();
    return {adcPowered, drvOn, penIrqEn, yMinusOn};
  endfunction

  // Runs one conversion; optionally injects a conflicting command at edge injectAt.
  task automatic runConv(input bit hiRes, input logic [1:0] pd, input logic [11:0] pattern,
                         input int injectAt, output int cycles, output logic [11:0] res);
    int div = hiRes ? 8 : 4;
    int bits = hiRes ? 12 : 8;
    int n = 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdHiRes = hiRes; cmdPd = pd;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    while (n < 400) begin
      int nxt = n + 1;
      if ((nxt % div) == 0 && (nxt / div) >= 5) cmpBit = pattern[bits - 1 - (nxt / div - 5)];
      else cmpBit = 1'b0;
      if (n == injectAt) begin
        cmdValid = 1'b1; cmdHiRes = !hiRes; cmdPd = ~pd;
      end else cmdValid = 1'b0;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 3) begin
        check(busy === 1'b1, "R5 busy during conversion", busy, 1);
        check(pwrVec() === 4'b1100, "R6 power while busy", pwrVec(), 4'b1100);
      end
      if (done === 1'b1) begin
        check(busy === 1'b0, "R5 busy low with done", busy, 0);
        break;
      end
    end
    cmdValid = 1'b0;
    cycles = n;
    res = result;
    @(posedge clk);
    @(negedge clk);
    check(done === 1'b0, "R5 done one cycle", done, 0);
  endtask

  task automatic testReset();
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done reset", {busy, done}, 0);
    check(pwrVec() === 4'b0011, "R1 power reset", pwrVec(), 4'b0011);
  endtask

  task automatic testHiRes();
    int c; logic [11:0] r;
    runConv(1'b1, 2'b00, 12'hA35, -1, c, r);
    check(c == 128, "R2 12-bit length", c, 128);
    check(r === 12'hA35, "R4 12-bit result order", r, 12'hA35);
    check(pwrVec() === 4'b0011, "R7 code 00 after done", pwrVec(), 4'b0011);
  endtask

  task automatic testLoRes();
    int c; logic [11:0] r;
    runConv(1'b0, 2'b01, 12'hFB1, -1, c, r);
    check(c == 48, "R3 8-bit length", c, 48);
    check(r === 12'h0B1, "R4 8-bit right-justified", r, 12'h0B1);
    check(pwrVec() === 4'b1100, "R8 code 01 after done", pwrVec(), 4'b1100);
  endtask

  task automatic testCode10();
    int c; logic [11:0] r;
    runConv(1'b0, 2'b10, 12'h0C3, -1, c, r);
    check(r === 12'h0C3, "R4 8-bit pattern 2", r, 12'h0C3);
    check(pwrVec() === 4'b0011, "R9 code 10 after done", pwrVec(), 4'b0011);
    runConv(1'b1, 2'b11, 12'h5E7, -1, c, r);
    check(c == 128, "R12 no wake-up delay", c, 128);
    check(pwrVec() === 4'b1100, "R10 code 11 after done", pwrVec(), 4'b1100);
  endtask

  task automatic testIgnore();
    int c; logic [11:0] r;
    runConv(1'b1, 2'b00, 12'h3C9, 20, c, r);
    check(c == 128, "R11 length unchanged by busy cmd", c, 128);
    check(r === 12'h3C9, "R11 result unchanged", r, 12'h3C9);
    check(pwrVec() === 4'b0011, "R11 power code kept", pwrVec(), 4'b0011);
    runConv(1'b0, 2'b01, 12'h05A, 10, c, r);
    check(c == 48, "R11 8-bit length kept", c, 48);
    check(pwrVec() === 4'b1100, "R11 code 01 kept", pwrVec(), 4'b1100);
  endtask

  initial begin
    #50000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHiRes();
    testLoRes();
    testCode10();
    testIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule